// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block builds MAC control frames that ask the link partner to stop sending for a given number of pause quanta. It sits in front of the transmit datapath and hands over one byte per accepted beat on a valid/ready stream, with a last flag on the final byte. Frame check sequence, preamble and inter-frame gap are added further down the transmit path.

Software drives a 32-bit control register. Bit 0 is the send request, and the same bit reads back as a busy flag. Bits 31:16 hold the pause time and bit 7 turns off automatic frames. The receive FIFO layer supplies a flow-control request level. When that level falls, the block sends a frame with a pause time of zero on its own, so the partner may resume at once without waiting out the earlier pause.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset the register reads 0x00000000. Only bits 31:16, 7 and 0 can read as non-zero. Writing 0xFFFFFFFE reads back as 0xFFFF0080.
- R2: A write with bit 0 = 1 while bit 0 reads 0 makes bit 0 read 1 from the next cycle on, and exactly one pause frame is sent.
- R3: Bit 0 reads 0 on the cycle after the beat that accepts the last byte of the software frame. It reads 1 until then.
- R4: The frame bytes in order are: 01 80 C2 00 00 01; then the source address, bits 47:40 first; then 88 08; then 00 01; then the pause time, bits 15:8 then 7:0. The pause time is bits 31:16 of the write that started the frame, so 0x0100 asks for 256 quanta.
- R5: Each frame is 60 bytes long. Bytes 18 to 59 are 0x00, and tx_last is high only on byte 59.
- R6: When bit 7 is 0, a 1-to-0 transition of fc_req causes one frame whose pause time is 0x0000.
- R7: When bit 7 is 1, a falling fc_req causes no frame.
- R8: A write with bit 0 = 1 while bit 0 reads 1 starts no extra frame. The pause time and bit 7 from that write still take effect.
- R9: If a software request and an automatic request are waiting together, the software frame goes out first and the zero frame follows. Each is sent exactly once.
- R10: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last stay unchanged on the next cycle.
- R11: After the last byte is accepted, tx_valid is low for exactly the next cycle before any further frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 32 | Control register write value |
| reg_rd_data | output | 32 | Control register read value |
| fc_req | input | 1 | Flow-control request level from the receive FIFO layer |
| src_mac | input | 48 | Station source address |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Transmit path accepts the byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
Two things can be waiting in the same cycle: a software send request and an automatic zero-quanta request. The bench forces this case. It starts an automatic frame, holds tx_ready low so that frame stalls, and during the stall it writes a software request and drops fc_req a second time. After tx_ready is released, the captured frames are compared in order against a queue of expected pause times: the first zero frame, then the software frame, then exactly one more zero frame. A second overlap is a software write that arrives while a frame is in flight. The bench judges it through the register readback and the total frame count.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  localparam logic [47:0] PAUSE_DEST   = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_TYPE    = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE = 16'h0001;
  localparam int          HDR_BYTES    = 18;
  localparam int          TRIG_BIT     = 0;
  localparam int          NOAUTO_BIT   = 7;
  localparam int          PT_LSB       = 16;
endpackage

// File: rtl/pfg_ctrl_reg.sv
module pfg_ctrl_reg
  import pfg_pkg::*;
#(
  parameter int PT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  input  logic            fc_req,
  input  logic            sw_start,
  input  logic            zq_start,
  input  logic            sw_done,
  output logic [31:0]     rd_data,
  output logic            sw_req,
  output logic            zq_req,
  output logic [PT_W-1:0] sw_pt
);
  logic [PT_W-1:0] pt_q, pt_d, swpt_q, swpt_d;
  logic            noauto_q, noauto_d;
  logic            sw_req_q, sw_req_d, infl_q, infl_d, zq_q, zq_d, fc_q;
  logic            busy, trig, fc_fell;

  assign busy    = sw_req_q | infl_q;
  assign trig    = wr_en & wr_data[TRIG_BIT] & ~busy;
  assign fc_fell = fc_q & ~fc_req;

  always_comb begin
    pt_d     = pt_q;
    noauto_d = noauto_q;
    swpt_d   = swpt_q;
    if (wr_en) begin
      pt_d     = wr_data[PT_LSB +: PT_W];
      noauto_d = wr_data[NOAUTO_BIT];
    end
    if (trig) swpt_d = wr_data[PT_LSB +: PT_W];
    sw_req_d = sw_req_q;
    infl_d   = infl_q;
    if (trig)     sw_req_d = 1'b1;
    if (sw_start) begin sw_req_d = 1'b0; infl_d = 1'b1; end
    if (sw_done)  infl_d = 1'b0;
    zq_d = zq_q;
    if (zq_start) zq_d = 1'b0;
    if (fc_fell && !noauto_q) zq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pt_q     <= '0;
      swpt_q   <= '0;
      noauto_q <= 1'b0;
      sw_req_q <= 1'b0;
      infl_q   <= 1'b0;
      zq_q     <= 1'b0;
      fc_q     <= 1'b0;
    end else begin
      pt_q     <= pt_d;
      swpt_q   <= swpt_d;
      noauto_q <= noauto_d;
      sw_req_q <= sw_req_d;
      infl_q   <= infl_d;
      zq_q     <= zq_d;
      fc_q     <= fc_req;
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[PT_LSB +: PT_W]     = pt_q;
    rd_data[NOAUTO_BIT]         = noauto_q;
    rd_data[TRIG_BIT]           = busy;
  end

  assign sw_req = sw_req_q;
  assign zq_req = zq_q;
  assign sw_pt  = swpt_q;

  // R2
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_req_q, infl_q}));
  // R3
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_data[TRIG_BIT]) |-> $past(sw_done));
  // R8
  trig_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (infl_q && wr_en) |=> !sw_req_q);
endmodule

// File: rtl/pfg_byte_mux.sv
module pfg_byte_mux
  import pfg_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int PT_W  = 16
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [PT_W-1:0]  pt,
  input  logic [47:0]      src_mac,
  output logic [7:0]       byte_o
);
  localparam int AD_BYTES = 6;
  logic [7:0] hdr [HDR_BYTES];

  genvar g;
  generate
    for (g = 0; g < AD_BYTES; g++) begin : g_addr
      assign hdr[g]            = PAUSE_DEST[8*(AD_BYTES-1-g) +: 8];
      assign hdr[AD_BYTES + g] = src_mac[8*(AD_BYTES-1-g) +: 8];
    end
  endgenerate
  assign hdr[12] = CTRL_TYPE[15:8];
  assign hdr[13] = CTRL_TYPE[7:0];
  assign hdr[14] = PAUSE_OPCODE[15:8];
  assign hdr[15] = PAUSE_OPCODE[7:0];
  assign hdr[16] = pt[PT_W-1 -: 8];
  assign hdr[17] = pt[7:0];

  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < HDR_BYTES; i++)
      if (32'(idx) == i) byte_o = hdr[i];
  end
endmodule

// File: rtl/pfg_frame_seq.sv
module pfg_frame_seq #(
  parameter int FRAME_LEN = 60,
  parameter int PT_W      = 16,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic             zq_req,
  input  logic [PT_W-1:0]  sw_pt,
  input  logic             tx_ready,
  output logic             sw_start,
  output logic             zq_start,
  output logic             sw_done,
  output logic             tx_valid,
  output logic             tx_last,
  output logic [IDX_W-1:0] idx,
  output logic [PT_W-1:0]  pt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             act_q, act_d, sw_q, sw_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [PT_W-1:0]  pt_q, pt_d;
  logic             at_last;

  assign at_last  = (idx_q == LAST_IDX);
  assign sw_start = ~act_q & sw_req;
  assign zq_start = ~act_q & ~sw_req & zq_req;
  assign sw_done  = act_q & sw_q & tx_ready & at_last;

  always_comb begin
    act_d = act_q;
    sw_d  = sw_q;
    idx_d = idx_q;
    pt_d  = pt_q;
    if (!act_q) begin
      if (sw_start || zq_start) begin
        act_d = 1'b1;
        sw_d  = sw_start;
        idx_d = '0;
        pt_d  = sw_start ? sw_pt : '0;
      end
    end else if (tx_ready) begin
      if (at_last) act_d = 1'b0;
      else         idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sw_q  <= 1'b0;
      idx_q <= '0;
      pt_q  <= '0;
    end else begin
      act_q <= act_d;
      sw_q  <= sw_d;
      idx_q <= idx_d;
      pt_q  <= pt_d;
    end
  end

  assign tx_valid = act_q;
  assign tx_last  = act_q & at_last;
  assign idx      = idx_q;
  assign pt       = pt_q;

  // R9
  sw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid && sw_req && zq_req) |=> (tx_valid && sw_q));
  // R11
  frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(idx_q) && $stable(pt_q)));
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen #(
  parameter int FRAME_LEN = 60,
  parameter int PT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  output logic [31:0] reg_rd_data,
  input  logic        fc_req,
  input  logic [47:0] src_mac,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic        tx_last
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic             sw_req, zq_req, sw_start, zq_start, sw_done;
  logic [PT_W-1:0]  sw_pt, cur_pt;
  logic [IDX_W-1:0] idx;

  pfg_ctrl_reg #(.PT_W(PT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_data(reg_wr_data),
    .fc_req(fc_req), .sw_start(sw_start), .zq_start(zq_start),
    .sw_done(sw_done), .rd_data(reg_rd_data), .sw_req(sw_req),
    .zq_req(zq_req), .sw_pt(sw_pt)
  );

  pfg_frame_seq #(.FRAME_LEN(FRAME_LEN), .PT_W(PT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .zq_req(zq_req),
    .sw_pt(sw_pt), .tx_ready(tx_ready), .sw_start(sw_start),
    .zq_start(zq_start), .sw_done(sw_done), .tx_valid(tx_valid),
    .tx_last(tx_last), .idx(idx), .pt(cur_pt)
  );

  pfg_byte_mux #(.IDX_W(IDX_W), .PT_W(PT_W)) u_mux (
    .idx(idx), .pt(cur_pt), .src_mac(src_mac), .byte_o(tx_data)
  );

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> ($stable(tx_data) && $stable(tx_last)));
endmodule

// File: tb/pause_frame_gen_bench.sv
module pause_frame_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [31:0] reg_wr_data;
  logic [31:0] reg_rd_data;
  logic        fc_req;
  logic [47:0] src_mac;
  logic [7:0]  tx_data;
  logic        tx_valid, tx_ready, tx_last;

  int checks = 0, fails = 0, frames_seen = 0;
  int rmode = 1;
  bit done = 0;
  int exp_q[$];
  logic [7:0] fb [0:63];
  int fidx = 0;
  bit stall_prev = 0, busy_chk = 0;
  logic [7:0] prev_data;
  logic prev_last;

  always #5 clk = ~clk;

  pause_frame_gen u_pause_frame_gen (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .fc_req(fc_req), .src_mac(src_mac),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_last(tx_last)
  );

  function automatic logic [7:0] exp_byte(int i, logic [15:0] pt, logic [47:0] sa);
    case (i)
      0: return 8'h01;  1: return 8'h80;  2: return 8'hC2;
      3: return 8'h00;  4: return 8'h00;  5: return 8'h01;
      6: return sa[47:40]; 7: return sa[39:32]; 8: return sa[31:24];
      9: return sa[23:16]; 10: return sa[15:8]; 11: return sa[7:0];
      12: return 8'h88; 13: return 8'h08; 14: return 8'h00; 15: return 8'h01;
      16: return pt[15:8]; 17: return pt[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ready driver
  initial begin
    tx_ready = 1'b1;
    forever begin
      @(posedge clk); #2;
      case (rmode)
        0: tx_ready = 1'b0;
        1: tx_ready = 1'b1;
        default: tx_ready = (($urandom % 10) < 7);
      endcase
    end
  end

  // monitor, samples at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_chk) begin
        busy_chk = 0;
        check(reg_rd_data[0] == 1'b0, "R3 busy clear after last byte", 32'(reg_rd_data[0]), 0);
      end
      if (stall_prev) begin
        check(tx_valid && tx_data == prev_data && tx_last == prev_last,
              "R10 hold under stall", {22'd0, tx_valid, tx_last, tx_data},
              {22'd0, 1'b1, prev_last, prev_data});
      end
      stall_prev = tx_valid && !tx_ready;
      prev_data  = tx_data;
      prev_last  = tx_last;
      if (tx_valid && tx_ready) begin
        if (fidx < 64) fb[fidx] = tx_data;
        fidx++;
        if (tx_last) begin
          frames_seen++;
          check(fidx == 60, "R5 frame length", 32'(fidx), 60);
          if (exp_q.size() == 0) begin
            check(1'b0, "R8 unexpected frame", 1, 0);
          end else begin
            automatic int pt = exp_q.pop_front();
            automatic int bad = -1;
            for (int i = 0; i < 60; i++)
              if (bad < 0 && fb[i] !== exp_byte(i, pt[15:0], src_mac)) bad = i;
            if (bad < 0)
              check(1'b1, "R4 frame bytes", 0, 0);
            else
              check(1'b0, $sformatf("R4 byte %0d", bad), 32'(fb[bad]),
                    32'(exp_byte(bad, pt[15:0], src_mac)));
            if (pt[16]) busy_chk = 1;
          end
          fidx = 0;
        end
      end
    end
  end

  task automatic wr(logic [31:0] d);
    @(posedge clk); #2;
    reg_wr_en = 1'b1; reg_wr_data = d;
    @(posedge clk); #2;
    reg_wr_en = 1'b0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || tx_valid) @(negedge clk);
    cycles(2);
  endtask

  task automatic fc_pulse();
    @(posedge clk); #2; fc_req = 1'b1;
    cycles(3);
    fc_req = 1'b0;
  endtask

  initial begin
    int base;
    void'($urandom(32'd4711));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_data = '0; fc_req = 1'b0;
    src_mac = 48'h02_1A_2B_3C_4D_5E;
    cycles(4);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rd_data == 32'h0, "R1 reset value", reg_rd_data, 0);
    check(!tx_valid, "R1 idle after reset", 32'(tx_valid), 0);

    // R1 reserved bits
    wr(32'hFFFF_FFFE);
    @(negedge clk);
    check(reg_rd_data == 32'hFFFF_0080, "R1 reserved read zero", reg_rd_data, 32'hFFFF_0080);
    wr(32'h0);

    // R2 / R4 pause time 256 quanta
    exp_q.push_back(32'h1_0100);
    wr(32'h0100_0001);
    @(negedge clk);
    check(reg_rd_data[0], "R2 busy after trigger", 32'(reg_rd_data[0]), 1);
    drain();

    // R8 trigger while busy
    rmode = 0;
    base = frames_seen;
    exp_q.push_back(32'h1_00AA);
    wr(32'h00AA_0001);
    cycles(3);
    wr(32'h5555_0081);
    @(negedge clk);
    check(reg_rd_data == 32'h5555_0081, "R8 fields updated while busy", reg_rd_data, 32'h5555_0081);
    rmode = 1;
    drain();
    cycles(50);
    check(frames_seen == base + 1, "R8 single frame", 32'(frames_seen - base), 1);

    // R7 automatic frame disabled (bit 7 still set)
    base = frames_seen;
    fc_pulse();
    cycles(60);
    check(frames_seen == base && !tx_valid, "R7 no auto frame", 32'(frames_seen - base), 0);

    // R6 automatic zero frame
    wr(32'h0000_0000);
    base = frames_seen;
    exp_q.push_back(32'h0);
    fc_pulse();
    drain();
    check(frames_seen == base + 1, "R6 one zero frame", 32'(frames_seen - base), 1);

    // R9 both pending together behind a stalled frame
    rmode = 0;
    base = frames_seen;
    exp_q.push_back(32'h0);
    fc_pulse();
    cycles(3);
    exp_q.push_back(32'h1_1234);
    wr(32'h1234_0001);
    exp_q.push_back(32'h0);
    fc_pulse();
    cycles(2);
    @(negedge clk);
    check(reg_rd_data[0] && tx_valid, "R9 both waiting while stalled", 32'(reg_rd_data[0]), 1);
    rmode = 1;
    drain();
    cycles(30);
    check(frames_seen == base + 3, "R9 each sent once", 32'(frames_seen - base), 3);

    // random mix, random backpressure (R10, R11)
    rmode = 2;
    for (int it = 0; it < 16; it++) begin
      automatic logic [15:0] pt = 16'($urandom);
      automatic bit noauto = 1'($urandom);
      automatic bit do_sw = 1'($urandom);
      base = frames_seen;
      if (do_sw) begin
        exp_q.push_back({15'd0, 1'b1, pt});
        wr({pt, 8'd0, noauto, 6'd0, 1'b1});
      end else begin
        wr({pt, 8'd0, noauto, 7'd0});
        if (!noauto) exp_q.push_back(32'h0);
        fc_pulse();
      end
      @(negedge clk);
      check(reg_rd_data[31:16] == pt && reg_rd_data[7] == noauto, "R8 field readback",
            reg_rd_data, {pt, 8'd0, noauto, 7'd0});
      drain();
      cycles(20);
      check(frames_seen == base + ((do_sw || !noauto) ? 1 : 0), "R2 R6 R7 frame count",
            32'(frames_seen - base), 32'((do_sw || !noauto) ? 1 : 0));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule